// File: doc/BRIEF.md
# Return and Loop Stack with Pointer

This block is the hardware stack of a processor's program controller. It keeps return addresses, saved status words and loop context. Each row is split into a high half and a low half. A push or a pull moves both halves together. Register-transfer instructions can reach each half on its own through separate move-style ports. The pointer that marks the top row lives inside the block and can also be loaded and read over the general data path.

The pointer is six bits wide. The lower four bits count the occupied rows: a count of n makes row n-1 the top row, and a count of zero means the stack is empty. Bit 4 flags a push past the last row. Bit 5 flags a pull from an empty stack. Both flags are sticky, and whenever either is set the block raises a critical-error output for the interrupt logic.

Move access differs between the two halves. A move into the high half first advances the pointer and then writes, so it takes two clocks. A move out of the high half reads first and lowers the pointer one clock later. Moves of the low half act on the current top row and leave the pointer alone.

Top module: `sys_stack`

## Requirements
- R1: While reset is high and after it is released, `ptr_q` reads 0, `crit_err` is low and `top_hi`/`top_lo` read 0.
- R2: When `push` is accepted, `ptr_q` bits 3:0 rise by one at that clock edge. From the next cycle `top_hi`/`top_lo` show `push_hi`/`push_lo`.
- R3: When `pull` is accepted, `top_hi`/`top_lo` show the top row before the edge and `ptr_q` bits 3:0 drop by one at the edge. Rows come back in last-in, first-out order.
- R4: A pointer count n (bits 3:0) in the range 1..15 selects row n-1 through a one-hot row selector whose bit of weight 2^(n-1) is active. A count of 0 selects no row, and then `top_hi`/`top_lo` read 0.
- R5: A push with `ptr_q` = 0x0F leaves `ptr_q` = 0x10 and raises `crit_err`. No row is written.
- R6: A pull with `ptr_q` = 0x00 leaves `ptr_q` = 0x3F and raises `crit_err`.
- R7: Bits 5 (underflow) and 4 (stack error) of `ptr_q` stay set through later increments and decrements; only a pointer write or reset clears them. `crit_err` is high exactly when either bit is set.
- R8: `ptr_wr` loads `ptr_wdata` into `ptr_q` at the next edge. It takes priority over every other strobe in that clock, and none of those strobes has any effect.
- R9: `mv_hi_wr` raises the pointer at the first edge. At the second edge it writes `mv_wdata` (captured at the first) into the high half of the new top row.
- R10: `mv_hi_rd` loads `mv_rdata` with `top_hi` at the first edge, and the pointer drops by one at the second edge.
- R11: `mv_lo_wr` writes `mv_wdata` into the low half of the current top row, and `mv_lo_rd` loads `mv_rdata` with `top_lo`. Neither changes `ptr_q` or the high half.
- R12: With the block idle, one strobe acts per clock, in the order `ptr_wr`, `push`, `pull`, `mv_hi_wr`, `mv_hi_rd`, `mv_lo_wr`, `mv_lo_rd`. In the second clock of a high-half move, every strobe except `ptr_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Push both halves |
| push_hi | input | 16 | High half to push |
| push_lo | input | 16 | Low half to push |
| pull | input | 1 | Pull the top row |
| top_hi | output | 16 | High half of the top row (combinational) |
| top_lo | output | 16 | Low half of the top row (combinational) |
| mv_hi_wr | input | 1 | Move into the high half (pre-increment) |
| mv_hi_rd | input | 1 | Move out of the high half (post-decrement) |
| mv_lo_wr | input | 1 | Move into the low half of the top row |
| mv_lo_rd | input | 1 | Move out of the low half of the top row |
| mv_wdata | input | 16 | Data for move writes |
| mv_rdata | output | 16 | Registered result of move reads |
| ptr_wr | input | 1 | Load the pointer |
| ptr_wdata | input | 6 | Value to load into the pointer |
| ptr_q | output | 6 | Pointer: bit 5 underflow, bit 4 error, bits 3:0 count |
| crit_err | output | 1 | High while either pointer flag is set |

## Verification
The main function is exercised with three distinct row patterns. They are pushed and then pulled back in order, which shows whether the data returns last-in, first-out and whether the pointer steps by exactly one each time. Loading the pointer straight to 1 and 2 proves that the row selector maps each count to the row beneath it. Count 0, 15 and the flagged values separate the empty case, the overflow wrap, the underflow wrap and the sticky flag behaviour. Strobes that collide, and strobes that arrive during the second clock of a high-half move, show whether the priority order and the ignore rule hold, because an ignored push would otherwise change the pointer or a stored row.

// File: rtl/sys_stack_pkg.sv
package sys_stack_pkg;
  typedef enum logic [1:0] {
    MV_IDLE    = 2'd0,
    MV_HI_WR_P = 2'd1,
    MV_HI_RD_P = 2'd2
  } mv_state_t;
endpackage

// File: rtl/ss_row_dec.sv
// Turns a pointer count into a one-hot row selector: count n -> row n-1.
module ss_row_dec #(
  parameter int IDX_W = 4,
  parameter int ROWS  = 15
) (
  input  logic [IDX_W-1:0] idx,
  output logic [ROWS-1:0]  sel
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign sel[r] = (idx == IDX_W'(r + 1));
  end
endmodule

// File: rtl/ss_array.sv
// Row storage with separate write enables per half and an AND-OR top read.
module ss_array #(
  parameter int HALF_W = 16,
  parameter int ROWS   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   hi_we,
  input  logic [ROWS-1:0]   lo_we,
  input  logic [HALF_W-1:0] hi_d,
  input  logic [HALF_W-1:0] lo_d,
  input  logic [ROWS-1:0]   rd_sel,
  output logic [HALF_W-1:0] rd_hi,
  output logic [HALF_W-1:0] rd_lo
);
  logic [HALF_W-1:0] hi_mem [ROWS];
  logic [HALF_W-1:0] lo_mem [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (hi_we[r]) hi_mem[r] <= hi_d;
      if (lo_we[r]) lo_mem[r] <= lo_d;
    end
  end

  always_comb begin
    rd_hi = '0;
    rd_lo = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_sel[r]) begin
        rd_hi = rd_hi | hi_mem[r];
        rd_lo = rd_lo | lo_mem[r];
      end
    end
  end

  AST_ONE_ROW_HI: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hi_we)) else $error("two high rows written");  // R4
  AST_ONE_ROW_LO: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lo_we)) else $error("two low rows written");   // R4
endmodule

// File: rtl/ss_ptr_ctl.sv
// Pointer register, sticky flags, strobe priority and the two-clock move sequencer.
module ss_ptr_ctl
  import sys_stack_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int PW   = IDX_W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pull,
  input  logic          mv_hi_wr,
  input  logic          mv_hi_rd,
  input  logic          mv_lo_wr,
  input  logic          mv_lo_rd,
  input  logic          ptr_wr,
  input  logic [PW-1:0] ptr_wdata,
  output logic [PW-1:0] ptr_q,
  output logic          crit_err,
  output logic          do_push,
  output logic          do_hi_cap,
  output logic          do_hi_commit,
  output logic          do_lo_wr,
  output logic          do_rd_hi,
  output logic          do_rd_lo
);
  mv_state_t     st_q, st_d;
  logic          idle, free;
  logic          do_pull, do_dec_late;
  logic [PW-1:0] up_raw, dn_raw, up_v, dn_v, ptr_d;

  assign idle = (st_q == MV_IDLE);
  assign free = idle && !ptr_wr;

  always_comb begin
    do_push      = free && push;
    do_pull      = free && !push && pull;
    do_hi_cap    = free && !push && !pull && mv_hi_wr;
    do_rd_hi     = free && !push && !pull && !mv_hi_wr && mv_hi_rd;
    do_lo_wr     = free && !push && !pull && !mv_hi_wr && !mv_hi_rd && mv_lo_wr;
    do_rd_lo     = free && !push && !pull && !mv_hi_wr && !mv_hi_rd && !mv_lo_wr && mv_lo_rd;
    do_hi_commit = (st_q == MV_HI_WR_P);
    do_dec_late  = (st_q == MV_HI_RD_P) && !ptr_wr;
  end

  // Six-bit wrap with the two flag bits kept sticky.
  assign up_raw = ptr_q + PW'(1);
  assign dn_raw = ptr_q - PW'(1);
  assign up_v   = {up_raw[PW-1:IDX_W] | ptr_q[PW-1:IDX_W], up_raw[IDX_W-1:0]};
  assign dn_v   = {dn_raw[PW-1:IDX_W] | ptr_q[PW-1:IDX_W], dn_raw[IDX_W-1:0]};

  always_comb begin
    if (ptr_wr)                     ptr_d = ptr_wdata;
    else if (do_push || do_hi_cap)  ptr_d = up_v;
    else if (do_pull || do_dec_late) ptr_d = dn_v;
    else                            ptr_d = ptr_q;
  end

  always_comb begin
    st_d = MV_IDLE;
    if (do_hi_cap)     st_d = MV_HI_WR_P;
    else if (do_rd_hi) st_d = MV_HI_RD_P;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      crit_err <= 1'b0;
      st_q     <= MV_IDLE;
    end else begin
      ptr_q    <= ptr_d;
      crit_err <= |ptr_d[PW-1:IDX_W];
      st_q     <= st_d;
    end
  end

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
    (push && !ptr_wr && st_q == MV_IDLE) |=>
      ptr_q[IDX_W-1:0] == $past(ptr_q[IDX_W-1:0]) + IDX_W'(1)) else $error("push step");  // R2
  AST_PULL_DEC: assert property (@(posedge clk) disable iff (rst)
    (pull && !push && !ptr_wr && st_q == MV_IDLE) |=>
      ptr_q[IDX_W-1:0] == $past(ptr_q[IDX_W-1:0]) - IDX_W'(1)) else $error("pull step");  // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> ptr_q == $past(ptr_wdata)) else $error("pointer load");  // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !ptr_wr |=> (ptr_q[PW-1:IDX_W] & $past(ptr_q[PW-1:IDX_W])) == $past(ptr_q[PW-1:IDX_W]))
    else $error("flag dropped");  // R7
  AST_LO_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (st_q == MV_IDLE && !ptr_wr && !push && !pull && !mv_hi_wr && !mv_hi_rd && (mv_lo_wr || mv_lo_rd))
      |=> $stable(ptr_q)) else $error("low move moved pointer");  // R11
  AST_HI_RD_LATE: assert property (@(posedge clk) disable iff (rst)
    (st_q == MV_IDLE && !ptr_wr && !push && !pull && !mv_hi_wr && mv_hi_rd) |=> $stable(ptr_q))
    else $error("high read moved pointer early");  // R10
  AST_HI_WR_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == MV_HI_WR_P && !ptr_wr) |=> $stable(ptr_q)) else $error("second clock moved pointer");  // R12
endmodule

// File: rtl/sys_stack.sv
module sys_stack
  import sys_stack_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 4,
  localparam int ROWS  = (1 << IDX_W) - 1,
  localparam int PW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [HALF_W-1:0] push_hi,
  input  logic [HALF_W-1:0] push_lo,
  input  logic              pull,
  output logic [HALF_W-1:0] top_hi,
  output logic [HALF_W-1:0] top_lo,
  input  logic              mv_hi_wr,
  input  logic              mv_hi_rd,
  input  logic              mv_lo_wr,
  input  logic              mv_lo_rd,
  input  logic [HALF_W-1:0] mv_wdata,
  output logic [HALF_W-1:0] mv_rdata,
  input  logic              ptr_wr,
  input  logic [PW-1:0]     ptr_wdata,
  output logic [PW-1:0]     ptr_q,
  output logic              crit_err
);
  logic do_push, do_hi_cap, do_hi_commit, do_lo_wr, do_rd_hi, do_rd_lo;
  logic [ROWS-1:0]   sel_cur, sel_nxt, hi_we, lo_we;
  logic [HALF_W-1:0] hi_d, lo_d, hold_q;
  logic [IDX_W-1:0]  idx_nxt;

  ss_ptr_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst(rst), .push(push), .pull(pull),
    .mv_hi_wr(mv_hi_wr), .mv_hi_rd(mv_hi_rd), .mv_lo_wr(mv_lo_wr), .mv_lo_rd(mv_lo_rd),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ptr_q(ptr_q), .crit_err(crit_err),
    .do_push(do_push), .do_hi_cap(do_hi_cap), .do_hi_commit(do_hi_commit),
    .do_lo_wr(do_lo_wr), .do_rd_hi(do_rd_hi), .do_rd_lo(do_rd_lo)
  );

  assign idx_nxt = ptr_q[IDX_W-1:0] + IDX_W'(1);

  ss_row_dec #(.IDX_W(IDX_W), .ROWS(ROWS)) u_dec_cur (.idx(ptr_q[IDX_W-1:0]), .sel(sel_cur));
  ss_row_dec #(.IDX_W(IDX_W), .ROWS(ROWS)) u_dec_nxt (.idx(idx_nxt), .sel(sel_nxt));

  always_comb begin
    hi_we = '0;
    lo_we = '0;
    hi_d  = push_hi;
    lo_d  = push_lo;
    if (do_push) begin
      hi_we = sel_nxt;
      lo_we = sel_nxt;
    end else begin
      if (do_hi_commit) begin
        hi_we = sel_cur;
        hi_d  = hold_q;
      end
      if (do_lo_wr) begin
        lo_we = sel_cur;
        lo_d  = mv_wdata;
      end
    end
  end

  ss_array #(.HALF_W(HALF_W), .ROWS(ROWS)) u_arr (
    .clk(clk), .rst(rst), .hi_we(hi_we), .lo_we(lo_we), .hi_d(hi_d), .lo_d(lo_d),
    .rd_sel(sel_cur), .rd_hi(top_hi), .rd_lo(top_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      mv_rdata <= '0;
    end else begin
      if (do_hi_cap) hold_q <= mv_wdata;
      if (do_rd_hi)      mv_rdata <= top_hi;
      else if (do_rd_lo) mv_rdata <= top_lo;
    end
  end

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ptr_q[IDX_W-1:0] == '0) |-> (top_hi == '0 && top_lo == '0)) else $error("empty top nonzero");  // R4
endmodule

// File: tb/sys_stack_bench.sv
module sys_stack_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        push, pull, mv_hi_wr, mv_hi_rd, mv_lo_wr, mv_lo_rd, ptr_wr;
  logic [15:0] push_hi, push_lo, mv_wdata;
  logic [5:0]  ptr_wdata;
  logic [15:0] top_hi, top_lo, mv_rdata;
  logic [5:0]  ptr_q;
  logic        crit_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_stack u_sys_stack (
    .clk(clk), .rst(rst), .push(push), .push_hi(push_hi), .push_lo(push_lo), .pull(pull),
    .top_hi(top_hi), .top_lo(top_lo), .mv_hi_wr(mv_hi_wr), .mv_hi_rd(mv_hi_rd),
    .mv_lo_wr(mv_lo_wr), .mv_lo_rd(mv_lo_rd), .mv_wdata(mv_wdata), .mv_rdata(mv_rdata),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ptr_q(ptr_q), .crit_err(crit_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    push = 0; pull = 0; mv_hi_wr = 0; mv_hi_rd = 0; mv_lo_wr = 0; mv_lo_rd = 0; ptr_wr = 0;
    push_hi = '0; push_lo = '0; mv_wdata = '0; ptr_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_ptr(input logic [5:0] v);
    ptr_wr = 1; ptr_wdata = v; step(); idle_inputs();
  endtask

  task automatic do_push(input logic [15:0] h, input logic [15:0] l);
    push = 1; push_hi = h; push_lo = l; step(); idle_inputs();
  endtask

  task automatic do_pull();
    pull = 1; step(); idle_inputs();
  endtask

  task automatic t_reset();
    rst = 1; idle_inputs();
    repeat (3) step();
    check("R1", "ptr in reset", 32'(ptr_q), 32'h0);
    rst = 0; step();
    check("R1", "ptr after reset", 32'(ptr_q), 32'h0);
    check("R1", "crit_err after reset", 32'(crit_err), 32'h0);
    check("R1", "top after reset", {top_hi, top_lo}, 32'h0);
  endtask

  task automatic t_push_pull();
    for (int k = 1; k <= 3; k++) begin
      do_push(16'(k * 16'h1111), 16'(16'hA000 + k));
      check("R2", "ptr after push", 32'(ptr_q), 32'(k));
      check("R2", "top after push", {top_hi, top_lo}, {16'(k * 16'h1111), 16'(16'hA000 + k)});
    end
    for (int k = 3; k >= 1; k--) begin
      check("R3", "top before pull", {top_hi, top_lo}, {16'(k * 16'h1111), 16'(16'hA000 + k)});
      do_pull();
      check("R3", "ptr after pull", 32'(ptr_q), 32'(k - 1));
    end
    check("R4", "empty top", {top_hi, top_lo}, 32'h0);
    check("R1", "no error after balanced use", 32'(crit_err), 32'h0);
  endtask

  task automatic t_row_select();
    load_ptr(6'd2);
    check("R4", "count 2 selects row 1", {top_hi, top_lo}, 32'h2222A002);
    load_ptr(6'd1);
    check("R4", "count 1 selects row 0", {top_hi, top_lo}, 32'h1111A001);
  endtask

  task automatic t_low_moves();
    mv_lo_wr = 1; mv_wdata = 16'h5A5A; step(); idle_inputs();
    check("R11", "ptr after low write", 32'(ptr_q), 32'h1);
    check("R11", "top after low write", {top_hi, top_lo}, 32'h11115A5A);
    mv_lo_rd = 1; step(); idle_inputs();
    check("R11", "low read data", 32'(mv_rdata), 32'h5A5A);
    check("R11", "ptr after low read", 32'(ptr_q), 32'h1);
  endtask

  task automatic t_high_write();
    mv_hi_wr = 1; mv_wdata = 16'hBEEF; step(); idle_inputs();
    check("R9", "ptr after first clock", 32'(ptr_q), 32'h2);
    check("R9", "high not yet written", 32'(top_hi), 32'h2222);
    push = 1; push_hi = 16'hDEAD; push_lo = 16'hDEAD; step(); idle_inputs();
    check("R12", "push ignored in second clock", 32'(ptr_q), 32'h2);
    check("R9", "high written in second clock", {top_hi, top_lo}, 32'hBEEFA002);
  endtask

  task automatic t_high_read();
    mv_hi_rd = 1; step(); idle_inputs();
    check("R10", "high read data", 32'(mv_rdata), 32'hBEEF);
    check("R10", "ptr held in first clock", 32'(ptr_q), 32'h2);
    step();
    check("R10", "ptr drops in second clock", 32'(ptr_q), 32'h1);
  endtask

  task automatic t_overflow();
    load_ptr(6'h0E);
    do_push(16'h0F0F, 16'hF0F0);
    check("R2", "push into last row", {top_hi, top_lo}, 32'h0F0FF0F0);
    do_push(16'hFFFF, 16'hFFFF);
    check("R5", "ptr after overflow", 32'(ptr_q), 32'h10);
    check("R5", "crit_err after overflow", 32'(crit_err), 32'h1);
    load_ptr(6'h0F);
    check("R5", "last row not overwritten", {top_hi, top_lo}, 32'h0F0FF0F0);
    check("R8", "pointer write clears error", 32'(crit_err), 32'h0);
  endtask

  task automatic t_underflow();
    load_ptr(6'h00);
    do_pull();
    check("R6", "ptr after underflow", 32'(ptr_q), 32'h3F);
    check("R6", "crit_err after underflow", 32'(crit_err), 32'h1);
    do_push(16'h1234, 16'h5678);
    check("R7", "flags kept on increment", 32'(ptr_q), 32'h30);
    do_pull();
    check("R7", "flags kept on decrement", 32'(ptr_q), 32'h3F);
    load_ptr(6'h10);
    do_pull();
    check("R7", "error flag kept on decrement", 32'(ptr_q), 32'h1F);
    check("R7", "crit_err with error flag", 32'(crit_err), 32'h1);
  endtask

  task automatic t_priority();
    load_ptr(6'd2);
    ptr_wr = 1; ptr_wdata = 6'd5; push = 1; push_hi = 16'h7777; push_lo = 16'h7777; step(); idle_inputs();
    check("R8", "pointer write wins over push", 32'(ptr_q), 32'h5);
    load_ptr(6'd3);
    check("R8", "row 2 untouched by blocked push", {top_hi, top_lo}, 32'h3333A003);
    push = 1; pull = 1; push_hi = 16'h4444; push_lo = 16'h4040; step(); idle_inputs();
    check("R12", "push wins over pull", 32'(ptr_q), 32'h4);
    check("R12", "pushed row on top", {top_hi, top_lo}, 32'h44444040);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    t_reset();
    t_push_pull();
    t_row_select();
    t_low_moves();
    t_high_write();
    t_high_read();
    t_overflow();
    t_underflow();
    t_priority();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule